// File: doc/BRIEF.md
# Accumulator Saturating Extract Unit

This unit takes a 64-bit signed multiply-accumulate result, supplied as an upper and a lower 32-bit word, and turns it into one 32-bit result clamped to a chosen range. An 8-bit mode code picks the range. Three codes clamp symmetrically to 32, 16 or 8 bits. One code applies a lopsided clamp near the 8/9-bit boundary. One code clamps to 48 bits and then keeps bits 47:16. The mode code comes either from the low byte of a source register or from an immediate field.

Each accepted operation produces one registered result one clock later. The result comes with a write-enable for the destination register, which stays low when the mode code is not recognised. Every operation clears the carry flag and copies the sticky accumulator-overflow bit into the overflow flag, whatever the mode code.

Top module: `sx_extract_sat`

## Requirements
- R1: While reset is asserted, and after it is released, out_valid, out_we, out_data, flag_c and flag_v are all zero until the first operation.
- R2: When mode_from_imm is 1, the mode code is mode_imm and mode_reg_lo is ignored. When mode_from_imm is 0, the mode code is mode_reg_lo and mode_imm is ignored.
- R3: Mode code 8'h20: a value A above 2^31-1 gives 32'h7FFFFFFF, a value below -2^31 gives 32'h80000000, and any other value gives A[31:0].
- R4: Mode code 8'h10: A above 32767 gives 32'h00007FFF, A below -32768 gives 32'h00008000, and any other value gives A[31:0].
- R5: Mode code 8'h08: A above 127 gives 32'h0000007F, A below -128 gives 32'h00000080, and any other value gives A[31:0].
- R6: Mode code 8'h09: A above 128 gives 32'h00000080, A below -127 gives 32'h00000081, and any other value gives A[31:0]. The values 128 and -127 pass unchanged.
- R7: Mode code 8'h30: A is first clamped to [-2^47, 2^47-1], then shifted right arithmetically by 16. The result is the low 32 bits of that shift, so the limits give 32'h7FFFFFFF and 32'h80000000.
- R8: Any other mode code gives out_we = 0 and out_data = 0. The flags are still updated.
- R9: Every operation sets flag_c to 0 and flag_v to the ovf_sticky value presented with it. With no operation, both flags hold their values.
- R10: An operation presented with in_valid at a clock edge produces out_valid = 1, together with its out_we and out_data, in the following cycle. out_valid and out_we are 0 in a cycle that follows an edge without in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | An operation is presented this cycle |
| mode_from_imm | input | 1 | 1 selects mode_imm as the mode code, 0 selects mode_reg_lo |
| mode_reg_lo | input | 8 | Low byte of the mode source register |
| mode_imm | input | 8 | Immediate mode code |
| acc_hi | input | 32 | Upper word of the signed accumulator |
| acc_lo | input | 32 | Lower word of the signed accumulator |
| ovf_sticky | input | 1 | Sticky accumulator-overflow bit |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| out_we | output | 1 | Destination write-enable (recognised mode code) |
| out_data | output | 32 | Clamped result |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
A wrong mode decode shows up at the very next out_valid cycle: either the write-enable takes the wrong value or the clamp limit differs from the one the requirement gives. The sweep therefore places accumulator values one below, at and one above every limit of every mode, for both mode sources. The selector not in use always holds a different recognised code, so an input mux that picks the wrong source changes the result at once. Flag registers that are loaded without an operation only show up during idle cycles. For that reason ovf_sticky is toggled while in_valid is low, and flag_v is sampled before the next operation.

// File: rtl/sx_pkg.sv
package sx_pkg;
  // Recognised mode codes; the values are decoded by the instruction path.
  localparam logic [7:0] CODE_SAT32  = 8'h20;
  localparam logic [7:0] CODE_SAT16  = 8'h10;
  localparam logic [7:0] CODE_SAT8   = 8'h08;
  localparam logic [7:0] CODE_ODD9   = 8'h09;
  localparam logic [7:0] CODE_WIDE48 = 8'h30;

  // Lane selection after decode; the symmetric lanes come first, in
  // order of halving width.
  typedef enum logic [2:0] {
    KIND_SYM0  = 3'd0,
    KIND_SYM1  = 3'd1,
    KIND_SYM2  = 3'd2,
    KIND_ODD   = 3'd3,
    KIND_WIDE  = 3'd4,
    KIND_NONE  = 3'd7
  } sx_kind_e;

  localparam int NUM_SYM = 3;
endpackage

// File: rtl/sx_rst_sync.sv
module sx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sx_mode_decode.sv
module sx_mode_decode
  import sx_pkg::*;
(
  input  logic       from_imm,
  input  logic [7:0] reg_code,
  input  logic [7:0] imm_code,
  output sx_kind_e   kind,
  output logic       known
);
  logic [7:0] code;

  always_comb begin
    code = from_imm ? imm_code : reg_code;
    unique case (code)
      CODE_SAT32:  kind = KIND_SYM0;
      CODE_SAT16:  kind = KIND_SYM1;
      CODE_SAT8:   kind = KIND_SYM2;
      CODE_ODD9:   kind = KIND_ODD;
      CODE_WIDE48: kind = KIND_WIDE;
      default:     kind = KIND_NONE;
    endcase
    known = (kind != KIND_NONE);
  end
endmodule

// File: rtl/sx_range_clamp.sv
module sx_range_clamp #(
  parameter int ACC_W  = 64,
  parameter int WORD_W = 32,
  parameter int SHIFT  = 0,
  parameter logic signed [ACC_W-1:0] MAX_V = '0,
  parameter logic signed [ACC_W-1:0] MIN_V = '0,
  parameter logic [WORD_W-1:0] MAX_OUT = '0,
  parameter logic [WORD_W-1:0] MIN_OUT = '0
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic [WORD_W-1:0]       word_o
);
  // Limits are compared on the full signed value; the in-range path keeps
  // the window starting at SHIFT.
  always_comb begin
    if (acc_i > MAX_V)      word_o = MAX_OUT;
    else if (acc_i < MIN_V) word_o = MIN_OUT;
    else                    word_o = WORD_W'(acc_i >>> SHIFT);
  end
endmodule

// File: rtl/sx_extract_sat.sv
module sx_extract_sat
  import sx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int WIDE_W     = 48,
  parameter int WIDE_SHIFT = 16,
  parameter int ODD_MAX    = 128,
  parameter int ODD_MIN    = -127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              mode_from_imm,
  input  logic [7:0]        mode_reg_lo,
  input  logic [7:0]        mode_imm,
  input  logic [WORD_W-1:0] acc_hi,
  input  logic [WORD_W-1:0] acc_lo,
  input  logic              ovf_sticky,
  output logic              out_valid,
  output logic              out_we,
  output logic [WORD_W-1:0] out_data,
  output logic              flag_c,
  output logic              flag_v
);
  localparam int ACC_W = 2 * WORD_W;
  localparam logic [ACC_W-1:0] WIDE_MAX = (ACC_W'(1) << (WIDE_W - 1)) - ACC_W'(1);
  localparam logic [ACC_W-1:0] WIDE_MAX_SH = WIDE_MAX >> WIDE_SHIFT;

  logic rst_q_n;
  logic signed [ACC_W-1:0] acc;
  sx_kind_e kind;
  logic known;
  logic [WORD_W-1:0] sym_word [NUM_SYM];
  logic [WORD_W-1:0] odd_word;
  logic [WORD_W-1:0] wide_word;
  logic [WORD_W-1:0] sel_word;

  logic              valid_d, we_d, c_d, v_d;
  logic [WORD_W-1:0] data_d;
  logic              valid_q, we_q, c_q, v_q;
  logic [WORD_W-1:0] data_q;

  sx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  assign acc = $signed({acc_hi, acc_lo});

  sx_mode_decode u_dec (
    .from_imm(mode_from_imm), .reg_code(mode_reg_lo), .imm_code(mode_imm),
    .kind(kind), .known(known)
  );

  // Symmetric lanes: widths WORD_W, WORD_W/2, WORD_W/4.
  for (genvar g = 0; g < NUM_SYM; g++) begin : g_sym
    localparam int SW = WORD_W >> g;
    localparam logic [ACC_W-1:0] MX = (ACC_W'(1) << (SW - 1)) - ACC_W'(1);
    localparam logic [WORD_W-1:0] LO_OUT = WORD_W'(1) << (SW - 1);
    sx_range_clamp #(
      .ACC_W(ACC_W), .WORD_W(WORD_W), .SHIFT(0),
      .MAX_V($signed(MX)), .MIN_V($signed(~MX)),
      .MAX_OUT(MX[WORD_W-1:0]), .MIN_OUT(LO_OUT)
    ) u_lane (
      .acc_i(acc), .word_o(sym_word[g])
    );
  end

  sx_range_clamp #(
    .ACC_W(ACC_W), .WORD_W(WORD_W), .SHIFT(0),
    .MAX_V(ACC_W'(ODD_MAX)), .MIN_V(ACC_W'(ODD_MIN)),
    .MAX_OUT(WORD_W'(ODD_MAX)), .MIN_OUT(WORD_W'(-ODD_MIN + 2))
  ) u_odd (
    .acc_i(acc), .word_o(odd_word)
  );

  sx_range_clamp #(
    .ACC_W(ACC_W), .WORD_W(WORD_W), .SHIFT(WIDE_SHIFT),
    .MAX_V($signed(WIDE_MAX)), .MIN_V($signed(~WIDE_MAX)),
    .MAX_OUT(WIDE_MAX_SH[WORD_W-1:0]), .MIN_OUT(~WIDE_MAX_SH[WORD_W-1:0])
  ) u_wide (
    .acc_i(acc), .word_o(wide_word)
  );

  always_comb begin
    unique case (kind)
      KIND_SYM0: sel_word = sym_word[0];
      KIND_SYM1: sel_word = sym_word[1];
      KIND_SYM2: sel_word = sym_word[2];
      KIND_ODD:  sel_word = odd_word;
      KIND_WIDE: sel_word = wide_word;
      default:   sel_word = '0;
    endcase
  end

  // Next-state logic: result and flags load only with an operation.
  always_comb begin
    valid_d = in_valid;
    we_d    = in_valid & known;
    data_d  = data_q;
    c_d     = c_q;
    v_d     = v_q;
    if (in_valid) begin
      data_d = sel_word;
      c_d    = 1'b0;
      v_d    = ovf_sticky;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      data_q  <= '0;
      c_q     <= 1'b0;
      v_q     <= 1'b0;
    end else begin
      valid_q <= valid_d;
      we_q    <= we_d;
      data_q  <= data_d;
      c_q     <= c_d;
      v_q     <= v_d;
    end
  end

  assign out_valid = valid_q;
  assign out_we    = we_q;
  assign out_data  = data_q;
  assign flag_c    = c_q;
  assign flag_v    = v_q;
endmodule

// File: rtl/sx_extract_sat_chk.sv
module sx_extract_sat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        mode_from_imm,
  input logic [7:0]  mode_reg_lo,
  input logic [7:0]  mode_imm,
  input logic        ovf_sticky,
  input logic        out_valid,
  input logic        out_we,
  input logic [31:0] out_data,
  input logic        flag_c,
  input logic        flag_v
);
  logic [7:0] eff_code;
  logic       code_known;
  assign eff_code   = mode_from_imm ? mode_imm : mode_reg_lo;
  assign code_known = (eff_code == 8'h20) || (eff_code == 8'h10) ||
                      (eff_code == 8'h08) || (eff_code == 8'h09) ||
                      (eff_code == 8'h30);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_we);
  a_r10_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);
  a_r2_known_writes: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && code_known |=> out_we);
  a_r8_unknown_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !code_known |=> !out_we && out_data == 32'h0);
  a_r9_carry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !flag_c);
  a_r9_v_copies_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> flag_v == $past(ovf_sticky));
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(flag_v) && $stable(flag_c));
  a_r5_byte_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && eff_code == 8'h08 |=>
      (out_data <= 32'h80) || (out_data >= 32'hFFFFFF80));
endmodule

bind sx_extract_sat sx_extract_sat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .mode_from_imm(mode_from_imm), .mode_reg_lo(mode_reg_lo), .mode_imm(mode_imm),
  .ovf_sticky(ovf_sticky), .out_valid(out_valid), .out_we(out_we),
  .out_data(out_data), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/sx_extract_sat_test.sv
`timescale 1ns/1ps
module sx_extract_sat_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, mode_from_imm, ovf_sticky;
  logic [7:0]  mode_reg_lo, mode_imm;
  logic [31:0] acc_hi, acc_lo;
  logic        out_valid, out_we, flag_c, flag_v;
  logic [31:0] out_data;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #4 clk = ~clk;

  sx_extract_sat uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_from_imm(mode_from_imm),
    .mode_reg_lo(mode_reg_lo), .mode_imm(mode_imm), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .ovf_sticky(ovf_sticky), .out_valid(out_valid), .out_we(out_we),
    .out_data(out_data), .flag_c(flag_c), .flag_v(flag_v)
  );

  function automatic string tag_of(input logic [7:0] code);
    case (code)
      8'h20: return "R3";
      8'h10: return "R4";
      8'h08: return "R5";
      8'h09: return "R6";
      8'h30: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Expected result from the requirement text, plain integer arithmetic.
  function automatic void model(input logic [7:0] code, input longint a,
                                output bit we, output logic [31:0] d);
    longint t;
    we = 1; d = a[31:0];
    case (code)
      8'h20: begin if (a > 64'sd2147483647) d = 32'h7FFFFFFF;
                   else if (a < -64'sd2147483648) d = 32'h80000000; end
      8'h10: begin if (a > 32767) d = 32'h00007FFF;
                   else if (a < -32768) d = 32'h00008000; end
      8'h08: begin if (a > 127) d = 32'h0000007F;
                   else if (a < -128) d = 32'h00000080; end
      8'h09: begin if (a > 128) d = 32'h00000080;
                   else if (a < -127) d = 32'h00000081; end
      8'h30: begin
        t = a;
        if (t > (64'sd1 <<< 47) - 1) t = (64'sd1 <<< 47) - 1;
        else if (t < -(64'sd1 <<< 47)) t = -(64'sd1 <<< 47);
        t = t >>> 16;
        d = t[31:0];
      end
      default: begin we = 0; d = 32'h0; end
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge after checking.
  task automatic apply(input logic [7:0] code, input bit use_imm,
                       input longint a, input bit sticky);
    bit exp_we; logic [31:0] exp_d;
    model(code, a, exp_we, exp_d);
    in_valid      = 1'b1;
    mode_from_imm = use_imm;
    // The unused source always carries a different recognised code (R2).
    if (use_imm) begin
      mode_imm = code; mode_reg_lo = (code == 8'h20) ? 8'h10 : 8'h20;
    end else begin
      mode_reg_lo = code; mode_imm = (code == 8'h30) ? 8'h08 : 8'h30;
    end
    acc_hi = a[63:32]; acc_lo = a[31:0];
    ovf_sticky = sticky;
    @(negedge clk);
    in_valid = 1'b0;
    n_vec++;
    if (out_valid !== 1'b1 || out_we !== exp_we || out_data !== exp_d ||
        flag_c !== 1'b0 || flag_v !== sticky) begin
      n_bad++;
      $display("FAIL %s/R2/R9/R10 code=%h imm=%0d acc=%h: actual v=%b we=%b d=%h c=%b v=%b expected v=1 we=%b d=%h c=0 v=%b",
               tag_of(code), code, use_imm, a, out_valid, out_we, out_data,
               flag_c, flag_v, exp_we, exp_d, sticky);
    end
  endtask

  longint vals [26];
  logic [7:0] codes [9];

  initial begin
    vals = '{0, 1, -1, 127, 128, 129, -126, -127, -128, -129,
             32767, 32768, -32768, -32769,
             64'sd2147483647, 64'sd2147483648, -64'sd2147483648, -64'sd2147483649,
             (64'sd1 <<< 47) - 1, (64'sd1 <<< 47), -(64'sd1 <<< 47), -(64'sd1 <<< 47) - 1,
             64'sh7FFFFFFFFFFFFFFF, 64'sh8000000000000000,
             64'sh000000123456789A, -64'sh000000123456789A};
    codes = '{8'h20, 8'h10, 8'h08, 8'h09, 8'h30, 8'h00, 8'h21, 8'h88, 8'hFF};

    rst_n = 1'b0; in_valid = 1'b0; mode_from_imm = 1'b0; mode_reg_lo = 8'h20;
    mode_imm = 8'h20; acc_hi = 32'hFFFFFFFF; acc_lo = 32'h1; ovf_sticky = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid", {31'b0, out_valid}, 32'h0);
    check("R1", "out_we",    {31'b0, out_we},    32'h0);
    check("R1", "out_data",  out_data,           32'h0);
    check("R1", "flags",     {30'b0, flag_c, flag_v}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "post-release idle", {29'b0, out_valid, flag_c, flag_v}, 32'h0);

    // R2..R10 sweep: every code, every boundary value, both sources.
    for (int m = 0; m < 9; m++)
      for (int i = 0; i < 26; i++)
        for (int s = 0; s < 2; s++)
          apply(codes[m], s[0], vals[i], s[0] ^ i[0]);

    // R9: flags hold across idle cycles while ovf_sticky moves.
    apply(8'h20, 1'b0, 64'sd5, 1'b1);
    for (int k = 0; k < 3; k++) begin
      ovf_sticky = k[0];
      @(negedge clk);
      check("R9", "flag_v hold", {31'b0, flag_v}, 32'h1);
      check("R10", "idle valid/we", {30'b0, out_valid, out_we}, 32'h0);
    end
    // R8: unknown code still updates flags.
    apply(8'h7E, 1'b1, 64'sd99, 1'b0);
    check("R8", "flag_v after unknown", {31'b0, flag_v}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule